// File: doc/BRIEF.md
# CSR Neighbor-List Pair Streamer

This block walks a graph stored in compressed sparse row form and turns each stored edge into a pair of aligned, sorted neighbor lists. These pairs feed a set-intersection stage that counts triangles. The graph is undirected and has no self loops and no repeated edges. Every stored edge (u, v) is oriented so that v > u. The row of vertex u occupies column-index entries offset[u] up to offset[u+1]-1. The two arrays sit in small memories outside the block. The block reads them through three synchronous read ports, and each port returns data one cycle after its address.

After a `start` pulse the block visits the vertices 0 to `vertex_count`-1 in increasing order. For each neighbor v of u, taken in stored order, it sends the whole row of u on stream A. At the same time it fetches v from the row, uses v as a row index, and sends the row of v on stream B. Row u is therefore sent once per neighbor of u. A pair begins only after both lists of the previous pair have been accepted.

A stream beat transfers on a clock edge where valid and ready are both high. While valid is high and ready is low, the data, last and empty outputs hold their values. Ready may be held low for any number of cycles and may change freely. Valid never depends combinationally on ready.

Top module: `csr_pair_streamer`

## Requirements
- R1: After reset, `a_valid`, `b_valid` and `done` are low.
- R2: Vertices are visited in increasing id order. For a vertex u whose row holds d entries, stream A carries exactly d lists, each one a copy of u's row in stored order, with `a_last` high only on the final entry. A vertex whose two offsets are equal produces no lists.
- R3: For the k-th neighbor v of u, the list on stream B is the row of v in stored order, with `b_last` high only on its final entry and `b_empty` low on every entry.
- R4: When the row of v is empty, stream B sends exactly one beat with `b_empty`=1, `b_last`=1 and `b_data`=0.
- R5: While a stream's valid is high and its ready is low, that stream keeps valid high and holds data, last and empty unchanged on the next cycle.
- R6: A stream never begins the list of pair p+1 until both lists of pair p have been fully accepted.
- R7: `done` is a single-cycle pulse. It goes high once per run, only after the last beat of the final pair has been accepted. With `vertex_count`=0, or when no vertex has neighbors, the pulse comes with no stream beats.
- R8: A `start` pulse during a run is ignored. The run produces exactly the same lists and exactly one `done` pulse, and no beats follow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk over the graph; ignored while a run is in progress |
| vertex_count | input | VID_W | Number of vertices to visit; held stable during a run |
| done | output | 1 | One-cycle pulse at the end of a run |
| ofs_rd_addr | output | VID_W | Address into the offset memory |
| ofs_rd_data | input | EIDX_W | Offset word, valid one cycle after its address |
| col_a_addr | output | EIDX_W | Column-index read address for stream A |
| col_a_data | input | VID_W | Column-index word for stream A, one cycle latency |
| col_b_addr | output | EIDX_W | Column-index read address for stream B and neighbor fetch |
| col_b_data | input | VID_W | Column-index word for port B, one cycle latency |
| a_valid | output | 1 | Stream A beat available |
| a_ready | input | 1 | Stream A consumer accepts |
| a_data | output | VID_W | Stream A vertex id |
| a_last | output | 1 | Final entry of the stream A list |
| b_valid | output | 1 | Stream B beat available |
| b_ready | input | 1 | Stream B consumer accepts |
| b_data | output | VID_W | Stream B vertex id |
| b_last | output | 1 | Final entry of the stream B list |
| b_empty | output | 1 | Stream B beat stands for an empty row |

## Verification
The bench builds the block with VID_W=16 and EDGE_DEPTH=64, so every offset is a 7-bit word and the memories hold a few dozen entries. At that size the bench can sweep every complete graph from 0 to 7 vertices and a family of sparse graphs from 1 to 8 vertices. It runs each graph with no back-pressure and under two pseudo-random ready patterns. Together these cover single-entry and full-length rows, empty source rows, empty neighbor rows, the zero-vertex run, and start pulses arriving in the middle of a run.

// File: rtl/csr_pair_pkg.sv
package csr_pair_pkg;

  typedef enum logic [1:0] {
    RD_IDLE,
    RD_FETCH,
    RD_SHOW
  } rd_state_e;

  typedef enum logic [3:0] {
    CT_IDLE,
    CT_RU0,
    CT_RU1,
    CT_RU2,
    CT_CHK,
    CT_GETV,
    CT_V1,
    CT_V2,
    CT_V3,
    CT_LAUNCH,
    CT_RUN
  } ct_state_e;

endpackage

// File: rtl/csr_row_reader.sv
module csr_row_reader
  import csr_pair_pkg::*;
#(
  parameter int VID_W       = 16,
  parameter int EIDX_W      = 11,
  parameter bit ALLOW_EMPTY = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [EIDX_W-1:0] lo,
  input  logic [EIDX_W-1:0] hi,
  output logic              idle,
  output logic [EIDX_W-1:0] mem_addr,
  input  logic [VID_W-1:0]  mem_rdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [VID_W-1:0]  out_data,
  output logic              out_last,
  output logic              out_empty
);

  rd_state_e         state;
  logic [EIDX_W-1:0] ptr;
  logic [EIDX_W-1:0] end_q;
  logic              empty_launch;

  // Variant choice: a reader may or may not stand in for an empty row with a marker beat
  generate
    if (ALLOW_EMPTY) begin : g_empty_beat
      assign empty_launch = launch && (lo == hi);
    end else begin : g_no_empty_beat
      assign empty_launch = 1'b0;
    end
  endgenerate

  always_comb begin
    case (state)
      RD_FETCH: mem_addr = ptr;
      RD_SHOW:  mem_addr = ptr + 1'b1;
      default:  mem_addr = lo;
    endcase
  end

  assign idle      = (state == RD_IDLE);
  assign out_valid = (state == RD_SHOW);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= RD_IDLE;
      ptr       <= '0;
      end_q     <= '0;
      out_data  <= '0;
      out_last  <= 1'b0;
      out_empty <= 1'b0;
    end else begin
      case (state)
        RD_IDLE: begin
          if (launch) begin
            ptr   <= lo;
            end_q <= hi;
            if (lo != hi) begin
              state <= RD_FETCH;
            end else if (empty_launch) begin
              state     <= RD_SHOW;
              out_data  <= '0;
              out_last  <= 1'b1;
              out_empty <= 1'b1;
            end
          end
        end
        RD_FETCH: begin
          out_data  <= mem_rdata;
          out_last  <= ((ptr + 1'b1) == end_q);
          out_empty <= 1'b0;
          state     <= RD_SHOW;
        end
        RD_SHOW: begin
          if (out_ready) begin
            if (out_last) begin
              state <= RD_IDLE;
            end else begin
              ptr   <= ptr + 1'b1;
              state <= RD_FETCH;
            end
          end
        end
        default: state <= RD_IDLE;
      endcase
    end
  end

  // R5: a stalled beat keeps its contents
  assert_hold_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
                                   $stable(out_last) && $stable(out_empty)));

  // R4: the empty marker is a lone, zero-valued final beat
  assert_empty_marker_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_empty) |-> (out_last && (out_data == '0)));

  // R6: a new list is only launched into an idle reader
  assert_launch_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> idle);

endmodule

// File: rtl/csr_pair_ctrl.sv
module csr_pair_ctrl
  import csr_pair_pkg::*;
#(
  parameter int VID_W  = 16,
  parameter int EIDX_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [VID_W-1:0]  vertex_count,
  output logic [VID_W-1:0]  ofs_addr,
  input  logic [EIDX_W-1:0] ofs_rdata,
  output logic [EIDX_W-1:0] col_addr,
  output logic              col_own,
  input  logic [VID_W-1:0]  col_rdata,
  output logic              launch,
  output logic [EIDX_W-1:0] a_lo,
  output logic [EIDX_W-1:0] a_hi,
  output logic [EIDX_W-1:0] b_lo,
  output logic [EIDX_W-1:0] b_hi,
  input  logic              a_idle,
  input  logic              b_idle,
  output logic              done
);

  ct_state_e         state;
  logic [VID_W-1:0]  u;
  logic [VID_W-1:0]  v;
  logic [EIDX_W-1:0] row_lo;
  logic [EIDX_W-1:0] row_hi;
  logic [EIDX_W-1:0] k_ptr;
  logic [EIDX_W-1:0] v_lo;
  logic [EIDX_W-1:0] v_hi;
  logic              last_vertex;

  assign last_vertex = (({1'b0, u} + 1'b1) == {1'b0, vertex_count});

  always_comb begin
    case (state)
      CT_RU1:  ofs_addr = u + 1'b1;
      CT_V1:   ofs_addr = col_rdata;
      CT_V2:   ofs_addr = v + 1'b1;
      default: ofs_addr = u;
    endcase
  end

  assign col_addr = k_ptr;
  assign col_own  = (state == CT_GETV);
  assign launch   = (state == CT_LAUNCH);
  assign a_lo     = row_lo;
  assign a_hi     = row_hi;
  assign b_lo     = v_lo;
  assign b_hi     = v_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= CT_IDLE;
      u      <= '0;
      v      <= '0;
      row_lo <= '0;
      row_hi <= '0;
      k_ptr  <= '0;
      v_lo   <= '0;
      v_hi   <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        CT_IDLE: begin
          if (start) begin
            if (vertex_count == '0) begin
              done <= 1'b1;
            end else begin
              u     <= '0;
              state <= CT_RU0;
            end
          end
        end
        CT_RU0: state <= CT_RU1;
        CT_RU1: begin
          row_lo <= ofs_rdata;
          state  <= CT_RU2;
        end
        CT_RU2: begin
          row_hi <= ofs_rdata;
          k_ptr  <= row_lo;
          state  <= CT_CHK;
        end
        CT_CHK: begin
          if (k_ptr == row_hi) begin
            if (last_vertex) begin
              done  <= 1'b1;
              state <= CT_IDLE;
            end else begin
              u     <= u + 1'b1;
              state <= CT_RU0;
            end
          end else begin
            state <= CT_GETV;
          end
        end
        CT_GETV: state <= CT_V1;
        CT_V1: begin
          v     <= col_rdata;
          state <= CT_V2;
        end
        CT_V2: begin
          v_lo  <= ofs_rdata;
          state <= CT_V3;
        end
        CT_V3: begin
          v_hi  <= ofs_rdata;
          state <= CT_LAUNCH;
        end
        CT_LAUNCH: state <= CT_RUN;
        CT_RUN: begin
          if (a_idle && b_idle) begin
            k_ptr <= k_ptr + 1'b1;
            state <= CT_CHK;
          end
        end
        default: state <= CT_IDLE;
      endcase
    end
  end

  // R7: the end-of-run indication lasts a single cycle
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2: the row being walked never moves backwards within a run
  assert_u_monotonic_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((state != CT_IDLE) && ($past(state) != CT_IDLE)) |-> (u >= $past(u)));

  // R3: the neighbor fetch always points inside the current row
  assert_kptr_in_row_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CT_GETV) |-> ((k_ptr >= row_lo) && (k_ptr < row_hi)));

  // R8: a run in progress is not restarted by start
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (state == CT_RUN)) |=> (state == CT_RUN || state == CT_CHK));

endmodule

// File: rtl/csr_pair_streamer.sv
module csr_pair_streamer
  import csr_pair_pkg::*;
#(
  parameter int VID_W      = 16,
  parameter int EDGE_DEPTH = 1024,
  localparam int EIDX_W    = $clog2(EDGE_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [VID_W-1:0]  vertex_count,
  output logic              done,
  output logic [VID_W-1:0]  ofs_rd_addr,
  input  logic [EIDX_W-1:0] ofs_rd_data,
  output logic [EIDX_W-1:0] col_a_addr,
  input  logic [VID_W-1:0]  col_a_data,
  output logic [EIDX_W-1:0] col_b_addr,
  input  logic [VID_W-1:0]  col_b_data,
  output logic              a_valid,
  input  logic              a_ready,
  output logic [VID_W-1:0]  a_data,
  output logic              a_last,
  output logic              b_valid,
  input  logic              b_ready,
  output logic [VID_W-1:0]  b_data,
  output logic              b_last,
  output logic              b_empty
);

  logic              launch;
  logic [EIDX_W-1:0] a_lo, a_hi, b_lo, b_hi;
  logic              a_idle, b_idle;
  logic              col_own;
  logic [EIDX_W-1:0] ctl_col_addr;
  logic [EIDX_W-1:0] rdb_addr;
  logic              a_empty_int;

  csr_pair_ctrl #(.VID_W(VID_W), .EIDX_W(EIDX_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .vertex_count (vertex_count),
    .ofs_addr     (ofs_rd_addr),
    .ofs_rdata    (ofs_rd_data),
    .col_addr     (ctl_col_addr),
    .col_own      (col_own),
    .col_rdata    (col_b_data),
    .launch       (launch),
    .a_lo         (a_lo),
    .a_hi         (a_hi),
    .b_lo         (b_lo),
    .b_hi         (b_hi),
    .a_idle       (a_idle),
    .b_idle       (b_idle),
    .done         (done)
  );

  csr_row_reader #(.VID_W(VID_W), .EIDX_W(EIDX_W), .ALLOW_EMPTY(1'b0)) u_rd_a (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch),
    .lo        (a_lo),
    .hi        (a_hi),
    .idle      (a_idle),
    .mem_addr  (col_a_addr),
    .mem_rdata (col_a_data),
    .out_valid (a_valid),
    .out_ready (a_ready),
    .out_data  (a_data),
    .out_last  (a_last),
    .out_empty (a_empty_int)
  );

  csr_row_reader #(.VID_W(VID_W), .EIDX_W(EIDX_W), .ALLOW_EMPTY(1'b1)) u_rd_b (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch),
    .lo        (b_lo),
    .hi        (b_hi),
    .idle      (b_idle),
    .mem_addr  (rdb_addr),
    .mem_rdata (col_b_data),
    .out_valid (b_valid),
    .out_ready (b_ready),
    .out_data  (b_data),
    .out_last  (b_last),
    .out_empty (b_empty)
  );

  // Port B is lent to the controller for the single cycle that fetches the neighbor id
  assign col_b_addr = col_own ? ctl_col_addr : rdb_addr;

  // R2: the source-row stream always carries real entries
  assert_a_not_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    a_valid |-> !a_empty_int);

  // R6: the neighbor fetch never steals port B from an active list
  assert_port_b_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    col_own |-> (a_idle && b_idle));

  // R7: no beat is on offer while the end of run is signalled
  assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!a_valid && !b_valid));

endmodule

// File: tb/tb_csr_pair_streamer.sv
module tb_csr_pair_streamer;
  localparam int VID_W      = 16;
  localparam int EDGE_DEPTH = 64;
  localparam int EIDX_W     = $clog2(EDGE_DEPTH + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [VID_W-1:0]  vertex_count = '0;
  logic              done;
  logic [VID_W-1:0]  ofs_rd_addr;
  logic [EIDX_W-1:0] ofs_rd_data;
  logic [EIDX_W-1:0] col_a_addr, col_b_addr;
  logic [VID_W-1:0]  col_a_data, col_b_data;
  logic              a_valid, a_ready, a_last;
  logic [VID_W-1:0]  a_data;
  logic              b_valid, b_ready, b_last, b_empty;
  logic [VID_W-1:0]  b_data;

  always #2.5 clk = ~clk;

  csr_pair_streamer #(.VID_W(VID_W), .EDGE_DEPTH(EDGE_DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .vertex_count(vertex_count), .done(done),
    .ofs_rd_addr(ofs_rd_addr), .ofs_rd_data(ofs_rd_data),
    .col_a_addr(col_a_addr), .col_a_data(col_a_data),
    .col_b_addr(col_b_addr), .col_b_data(col_b_data),
    .a_valid(a_valid), .a_ready(a_ready), .a_data(a_data), .a_last(a_last),
    .b_valid(b_valid), .b_ready(b_ready), .b_data(b_data), .b_last(b_last),
    .b_empty(b_empty)
  );

  logic [EIDX_W-1:0] ofs_mem [0:15];
  logic [VID_W-1:0]  col_mem [0:EDGE_DEPTH-1];

  always_ff @(posedge clk) begin
    ofs_rd_data <= ofs_mem[ofs_rd_addr[3:0]];
    col_a_data  <= col_mem[col_a_addr[5:0]];
    col_b_data  <= col_mem[col_b_addr[5:0]];
  end

  int n_checks = 0;
  int n_errors = 0;
  int cyc = 0;
  int mode = 0;
  int done_cnt = 0;
  int a_lists = 0, b_lists = 0;
  bit a_first = 1'b1, b_first = 1'b1;
  logic [15:0] lfsr = 16'hACE1;
  logic [17:0] exp_a [$];
  logic [17:0] exp_b [$];
  bit pa_stall = 1'b0, pb_stall = 1'b0;
  logic [17:0] pa_word, pb_word;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog actual=%0d expected<190000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  // Ready generation and output monitor, all away from the rising edge
  always @(negedge clk) begin
    logic [17:0] got, want;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (mode)
      0: begin a_ready = 1'b1; b_ready = 1'b1; end
      1: begin a_ready = lfsr[0] | lfsr[3]; b_ready = lfsr[1] | lfsr[6]; end
      default: begin a_ready = lfsr[0] & lfsr[5]; b_ready = lfsr[2] & lfsr[9]; end
    endcase
    if (rst_n) begin
      got = {1'b0, a_last, a_data};
      if (pa_stall) chk(a_valid && (got == pa_word), "R5 stream A hold", {13'd0, a_valid, got}, {13'd1, 1'b1, pa_word});
      got = {b_empty, b_last, b_data};
      if (pb_stall) chk(b_valid && (got == pb_word), "R5 stream B hold", {13'd0, b_valid, got}, {13'd1, 1'b1, pb_word});
      pa_stall = a_valid && !a_ready;
      pa_word  = {1'b0, a_last, a_data};
      pb_stall = b_valid && !b_ready;
      pb_word  = {b_empty, b_last, b_data};

      if (a_valid && a_ready) begin
        got = {1'b0, a_last, a_data};
        if (a_first) chk(b_lists >= a_lists, "R6 A list start", a_lists, b_lists);
        if (exp_a.size() == 0) chk(1'b0, "R2 extra A beat", {14'd0, got}, 0);
        else begin
          want = exp_a.pop_front();
          chk(got == want, "R2 A beat", {14'd0, got}, {14'd0, want});
        end
        a_first = a_last;
        if (a_last) a_lists++;
      end
      if (b_valid && b_ready) begin
        got = {b_empty, b_last, b_data};
        if (b_first) chk(a_lists >= b_lists, "R6 B list start", b_lists, a_lists);
        if (exp_b.size() == 0) chk(1'b0, "R3 extra B beat", {14'd0, got}, 0);
        else begin
          want = exp_b.pop_front();
          if (want[17]) chk(got == want, "R4 empty B beat", {14'd0, got}, {14'd0, want});
          else          chk(got == want, "R3 B beat", {14'd0, got}, {14'd0, want});
        end
        b_first = b_last;
        if (b_last) b_lists++;
      end
      if (done) begin
        done_cnt++;
        chk((exp_a.size() == 0) && (exp_b.size() == 0), "R7 done after final pair",
            exp_a.size() + exp_b.size(), 0);
      end
    end
  end

  function automatic bit has_edge(input int kind, input int u, input int v);
    if (kind == 0) return 1'b1;
    return ((u % 4) != 1) && ((v == u + 1) || (v == u + 3));
  endfunction

  task automatic build(input int kind, input int n);
    int e = 0;
    exp_a.delete();
    exp_b.delete();
    for (int u = 0; u < 16; u++) begin
      ofs_mem[u] = EIDX_W'(e);
      if (u < n) begin
        for (int v = u + 1; v < n; v++) begin
          if (has_edge(kind, u, v)) begin
            col_mem[e] = VID_W'(v);
            e++;
          end
        end
      end
    end
    for (int u = 0; u < n; u++) begin
      int lo = int'(ofs_mem[u]);
      int hi = int'(ofs_mem[u+1]);
      for (int k = lo; k < hi; k++) begin
        int v = int'(col_mem[k]);
        int vl = int'(ofs_mem[v]);
        int vh = int'(ofs_mem[v+1]);
        for (int j = lo; j < hi; j++) exp_a.push_back({1'b0, (j == hi - 1), col_mem[j]});
        if (vl == vh) exp_b.push_back({1'b1, 1'b1, 16'd0});
        else for (int j = vl; j < vh; j++) exp_b.push_back({1'b0, (j == vh - 1), col_mem[j]});
      end
    end
    vertex_count = VID_W'(n);
  endtask

  task automatic run_graph(input bit poke);
    int t = 0;
    done_cnt = 0;
    a_lists = 0; b_lists = 0;
    a_first = 1'b1; b_first = 1'b1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (done_cnt == 0 && t < 20000) begin
      @(negedge clk);
      t++;
      start = poke && (t == 6 || t == 41 || t == 97);
    end
    start = 1'b0;
    chk(done_cnt == 1, "R7 done seen", done_cnt, 1);
    repeat (30) @(negedge clk);
    chk(done_cnt == 1, poke ? "R8 single done" : "R7 single done", done_cnt, 1);
    chk(!a_valid && !b_valid, "R8 quiet after run", {a_valid, b_valid}, 0);
    chk(exp_a.size() == 0, "R2 all A lists sent", exp_a.size(), 0);
    chk(exp_b.size() == 0, "R3 all B lists sent", exp_b.size(), 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) ofs_mem[i] = '0;
    for (int i = 0; i < EDGE_DEPTH; i++) col_mem[i] = '0;
    a_ready = 1'b1;
    b_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk(!a_valid && !b_valid && !done, "R1 outputs in reset", {a_valid, b_valid, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!a_valid && !b_valid && !done, "R1 outputs after reset", {a_valid, b_valid, done}, 0);
    for (int m = 0; m < 3; m++) begin
      mode = m;
      for (int n = 0; n <= 7; n++) begin
        build(0, n);
        run_graph(m == 1);
      end
      for (int n = 1; n <= 8; n++) begin
        build(1, n);
        run_graph(m != 0);
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule